// File: doc/BRIEF.md
# Flash Busy Status Readback Generator

This block sits on the device side of a parallel flash array and decides what a read returns. While an internal program or erase cycle is running, normal array data is replaced by a status word. The status word can carry three signals: an inverted copy of one data bit from the word being programmed, a bit that flips on every status read, and a second flipping bit that marks accesses to an erase-suspended sector. When the cycle ends, reads return true array data again. The block also drives an open-drain style ready/busy indication. It pulls the shared line low for the whole internal cycle and releases it afterwards, so several devices can share one wired-OR line.

A read is taken on the rising edge of the read strobe. Its result appears on the data bus one clock later and stays there until the next strobe edge. The memory array, the high-voltage circuits and the duration of the cycle are not part of this block. A busy flag and an operation code are inputs.

Top module: `flash_status_readback`

## Requirements
- R1: During a busy read with operation code 1 (program), data bit 7 is the complement of bit 7 of the last loaded word.
- R2: During a busy read with operation code 2 (sector erase) or 3 (chip erase), data bit 7 is 0.
- R3: Successive busy reads return bit 6 alternating, each read the opposite of the previous busy read.
- R4: The first busy read after busy rises returns bit 6 = 0. This holds even when the strobe edge falls in the same clock as the busy rise.
- R5: A read while not busy, outside a suspended sector, returns the array data unchanged on all bits.
- R6: The pull-low output is 1 in the clock after busy_i is seen high and 0 in the clock after it is seen low.
- R7: While suspend is active, each read whose sector (address bits above the top SW bits boundary, i.e. address >> (AW-SW)) equals the suspended sector number flips bit 2. The first such read after suspend rises returns 0. When not busy, such a read returns 0 on every other bit.
- R8: During a busy read, every bit other than 7, 6 and 2 is 0.
- R9: After reset the data output is all zeros and the pull-low output is 0.
- R10: Only a rising strobe edge starts a read. The result appears one clock after the edge, and the output holds its value while the strobe stays high or stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| busy_i | input | 1 | Internal program/erase cycle running |
| op_i | input | 2 | Operation code: 1 program, 2 sector erase, 3 chip erase |
| last_data_i | input | DW | Last loaded data word |
| susp_i | input | 1 | Erase suspend active |
| susp_sector_i | input | SW | Suspended sector number |
| rd_i | input | 1 | Read strobe (level) |
| rd_addr_i | input | AW | Read address |
| array_data_i | input | DW | True array data for the read address |
| rd_data_o | output | DW | Read data bus |
| ryby_pull_o | output | 1 | 1 = pull the shared ready/busy line low |

## Verification
The start of a busy cycle and a read strobe edge can fall in the same clock. The toggle must then be cleared and consumed at once, so that read still reports bit 6 = 0. A directed case raises busy_i and the strobe in the same cycle. The random run also produces this collision, and the clearing of the suspend toggle, many times. Each result is judged against a cycle-exact bench model that treats a clear and a read in the same cycle as "clear, then read, then flip".

// File: rtl/flash_stat_pkg.sv
package flash_stat_pkg;
  typedef enum logic [1:0] {
    OP_NONE   = 2'd0,
    OP_PROG   = 2'd1,
    OP_SERASE = 2'd2,
    OP_CERASE = 2'd3
  } flash_op_e;

  // Bit 7 of the status word: inverted data bit on program, zero on erase
  function automatic logic poll_bit(input logic [1:0] op, input logic loaded_bit);
    return (op == OP_PROG) ? ~loaded_bit : 1'b0;
  endfunction
endpackage

// File: rtl/fsr_edge.sv
module fsr_edge #(
  parameter int N = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl,
  output logic [N-1:0] rise,
  output logic [N-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= lvl;
  end

  assign rise = lvl & ~q;
endmodule

// File: rtl/fsr_toggle.sv
module fsr_toggle (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic evt,
  output logic cur,
  output logic q
);
  // clear applies before a read that lands in the same cycle
  assign cur = clr ? 1'b0 : q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= 1'b0;
    else if (evt) q <= ~cur;
    else          q <= cur;
  end

  // R3: every counted read leaves the bit flipped relative to what it presented
  a_r3_flip_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> q == ~$past(cur));
  // R4 / R7: a start-of-cycle clear with no read leaves the bit at 0
  a_r4_clear_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !evt) |=> !q);
  a_r3_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !evt) |=> $stable(q));
endmodule

// File: rtl/fsr_readmux.sv
module fsr_readmux
  import flash_stat_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          busy,
  input  logic [1:0]    op,
  input  logic          loaded_bit7,
  input  logic          tog_main,
  input  logic          tog_susp,
  input  logic          sect_hit,
  input  logic [DW-1:0] array_data,
  output logic [DW-1:0] word
);
  localparam int POLL_BIT = 7;
  localparam int TOG_BIT  = 6;
  localparam int SUSP_BIT = 2;

  always_comb begin
    word = '0;
    if (busy) begin
      word[POLL_BIT] = poll_bit(op, loaded_bit7);
      word[TOG_BIT]  = tog_main;
      word[SUSP_BIT] = sect_hit & tog_susp;
    end else if (sect_hit) begin
      word[SUSP_BIT] = tog_susp;
    end else begin
      word = array_data;
    end
  end

  // R8: unused bits stay zero on a busy status word
  always_comb begin
    if (busy) begin
      a_r8_unused_zero: assert ((word & ~(DW'(1) << POLL_BIT | DW'(1) << TOG_BIT
                                | DW'(1) << SUSP_BIT)) == '0);
    end
  end
endmodule

// File: rtl/flash_status_readback.sv
module flash_status_readback
  import flash_stat_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 20,
  parameter int SW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          busy_i,
  input  logic [1:0]    op_i,
  input  logic [DW-1:0] last_data_i,
  input  logic          susp_i,
  input  logic [SW-1:0] susp_sector_i,
  input  logic          rd_i,
  input  logic [AW-1:0] rd_addr_i,
  input  logic [DW-1:0] array_data_i,
  output logic [DW-1:0] rd_data_o,
  output logic          ryby_pull_o
);
  localparam int SECT_SHIFT = AW - SW;
  localparam int EDGES      = 3;

  function automatic logic sector_match(input logic [AW-1:0] a, input logic [SW-1:0] s);
    return (a >> SECT_SHIFT) == AW'(s);
  endfunction

  // named internal events
  logic [EDGES-1:0] lvl, rise, lvl_q;
  logic rd_rise, busy_start, susp_start;
  logic sect_hit, busy_read, susp_read;
  logic tog_main_cur, tog_main_q, tog_susp_cur, tog_susp_q;
  logic [DW-1:0] next_word;

  assign lvl = {susp_i, busy_i, rd_i};

  fsr_edge #(.N(EDGES)) u_edges (
    .clk(clk), .rst_n(rst_n), .lvl(lvl), .rise(rise), .q(lvl_q)
  );

  assign rd_rise    = rise[0];
  assign busy_start = rise[1];
  assign susp_start = rise[2];
  assign sect_hit   = susp_i && sector_match(rd_addr_i, susp_sector_i);
  assign busy_read  = rd_rise && busy_i;
  assign susp_read  = rd_rise && sect_hit;

  fsr_toggle u_tog_main (
    .clk(clk), .rst_n(rst_n), .clr(busy_start), .evt(busy_read),
    .cur(tog_main_cur), .q(tog_main_q)
  );

  fsr_toggle u_tog_susp (
    .clk(clk), .rst_n(rst_n), .clr(susp_start), .evt(susp_read),
    .cur(tog_susp_cur), .q(tog_susp_q)
  );

  fsr_readmux #(.DW(DW)) u_mux (
    .busy(busy_i), .op(op_i), .loaded_bit7(last_data_i[7]),
    .tog_main(tog_main_cur), .tog_susp(tog_susp_cur), .sect_hit(sect_hit),
    .array_data(array_data_i), .word(next_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data_o   <= '0;
      ryby_pull_o <= 1'b0;
    end else begin
      if (rd_rise) rd_data_o <= next_word;
      ryby_pull_o <= busy_i;
    end
  end

  a_r1_prog_poll: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_read && op_i == OP_PROG) |=> rd_data_o[7] == ~$past(last_data_i[7]));
  a_r2_erase_poll: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_read && (op_i == OP_SERASE || op_i == OP_CERASE)) |=> !rd_data_o[7]);
  a_r4_first_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_read && busy_start) |=> !rd_data_o[6]);
  a_r5_true_data: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_rise && !busy_i && !sect_hit) |=> rd_data_o == $past(array_data_i));
  a_r6_pull_low: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i |=> ryby_pull_o);
  a_r6_release: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_i |=> !ryby_pull_o);
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_rise |=> $stable(rd_data_o));
  a_r10_edge_q: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lvl_q[0]) |-> $past(rd_i));
  a_r7_susp_zero_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (susp_read && !busy_i) |=> (rd_data_o & ~(DW'(1) << 2)) == '0);
endmodule

// File: tb/flash_status_readback_bench.sv
module flash_status_readback_bench;
  localparam int DW = 16;
  localparam int AW = 20;
  localparam int SW = 8;
  localparam int SHIFT = AW - SW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic busy = 0, susp = 0, rd = 0;
  logic [1:0] op = 0;
  logic [DW-1:0] last = 0, arr = 0;
  logic [SW-1:0] ssect = 8'h21;
  logic [AW-1:0] addr = 0;
  logic [DW-1:0] rd_data;
  logic ryby;

  int nchk = 0, nfail = 0;
  bit done = 0;

  // bench model state
  logic m_rd_q = 0, m_busy_q = 0, m_susp_q = 0, m_t6 = 0, m_t2 = 0;
  logic [DW-1:0] m_word = 0;

  always #10 clk = ~clk;

  flash_status_readback #(.DW(DW), .AW(AW), .SW(SW)) u_flash_status_readback (
    .clk(clk), .rst_n(rst_n), .busy_i(busy), .op_i(op), .last_data_i(last),
    .susp_i(susp), .susp_sector_i(ssect), .rd_i(rd), .rd_addr_i(addr),
    .array_data_i(arr), .rd_data_o(rd_data), .ryby_pull_o(ryby)
  );

  function automatic logic in_sector(input logic [AW-1:0] a, input logic [SW-1:0] s);
    return a[AW-1:SHIFT] == s;
  endfunction

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one clock: predict, clock, compare
  task automatic step();
    logic rise, bstart, sstart, t6, t2, hit, was_busy, first;
    logic [1:0] op_s;
    rise   = rd && !m_rd_q;
    bstart = busy && !m_busy_q;
    sstart = susp && !m_susp_q;
    t6 = bstart ? 1'b0 : m_t6;
    t2 = sstart ? 1'b0 : m_t2;
    hit = susp && in_sector(addr, ssect);
    was_busy = busy;
    first = bstart;
    op_s = op;
    if (rise) begin
      if (busy) begin
        m_word = '0;
        m_word[7] = (op == 2'd1) ? ~last[7] : 1'b0;
        m_word[6] = t6;
        m_word[2] = hit ? t2 : 1'b0;
        t6 = ~t6;
      end else if (hit) begin
        m_word = '0;
        m_word[2] = t2;
      end else begin
        m_word = arr;
      end
      if (hit) t2 = ~t2;
    end
    m_t6 = t6; m_t2 = t2;
    m_rd_q = rd; m_busy_q = busy; m_susp_q = susp;
    @(posedge clk);
    @(negedge clk);
    chk("R6 pull-low", {15'd0, ryby}, {15'd0, was_busy});
    if (!rise) chk("R10 hold", rd_data, m_word);
    else if (was_busy) begin
      chk(op_s == 2'd1 ? "R1 poll bit" : "R2 erase bit", {15'd0, rd_data[7]}, {15'd0, m_word[7]});
      chk(first ? "R4 first toggle" : "R3 toggle", {15'd0, rd_data[6]}, {15'd0, m_word[6]});
      chk("R7 suspend toggle", {15'd0, rd_data[2]}, {15'd0, m_word[2]});
      chk("R8 unused bits", rd_data & 16'hFF3B, 16'h0000);
    end else if (hit) chk("R7 suspended read", rd_data, m_word);
    else chk("R5 true data", rd_data, m_word);
  endtask

  initial begin
    int left = 0;
    int seed = 7;
    void'($urandom(seed));
    @(negedge clk);
    chk("R9 reset data", rd_data, '0);
    chk("R9 reset pull", {15'd0, ryby}, 16'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // directed: busy start and strobe edge in the same cycle
    busy = 1; op = 2'd1; last = 16'h0080; rd = 1; addr = 20'h00010;
    step();
    step(); step();          // strobe held high: no new read
    rd = 0; step();
    rd = 1; step();          // second read: bit 6 = 1
    rd = 0; op = 2'd3; step();
    rd = 1; step();          // erase poll
    rd = 0; busy = 0; step();
    arr = 16'hA5C3; rd = 1; step();
    // directed: suspended sector reads
    rd = 0; susp = 1; addr = {ssect, 12'h004}; step();
    rd = 1; step(); rd = 0; step(); rd = 1; step(); rd = 0;
    addr = {ssect + 8'd1, 12'h004}; step(); rd = 1; step(); rd = 0; susp = 0; step();
    // random run
    for (int i = 0; i < 4000; i++) begin
      if (left > 0) begin left--; busy = 1; end
      else begin
        busy = 0;
        if ($urandom_range(7) == 0) begin
          left = $urandom_range(20, 3);
          op = 2'($urandom_range(3, 1));
          last = 16'($urandom);
        end
      end
      if ($urandom_range(40) == 0) susp = ~susp;
      if ($urandom_range(1) == 0) rd = ~rd;
      addr = {ssect + 8'($urandom_range(1)), 12'($urandom)};
      arr = 16'($urandom);
      step();
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nfail++;
      nchk++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule